// File: doc/BRIEF.md
# Prefixed Nibble Instruction Decoder

This block sits between an instruction byte stream and an execution unit. It splits every incoming byte into an upper function nibble and a lower data nibble. A wide immediate is assembled over several bytes in an internal operand register. Two prefix functions extend that register, and neither produces output. Any other function completes an instruction. The decoder then presents a 4-bit function code and the 32-bit operand, which is the operand register ORed with the final data nibble, and clears the register.

When the completing function is the "operate" code, the assembled operand is not an immediate. It names an extended operation, and the decoder flags the output as secondary. Bytes arrive through a valid/ready handshake. Decoded instructions leave through a single output register with its own valid/ready handshake. A new byte is taken whenever that register is empty or is being drained in the same cycle.

Top module: `nib_prefix_decoder`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the operand register is zero, so the first completing byte yields an operand equal to its own data nibble.
- R2: An accepted byte whose upper nibble is neither 0x2, 0x6 nor 0xF is issued one cycle later with func equal to the upper nibble, operand equal to (operand register OR lower nibble), and is_secondary 0.
- R3: An accepted byte with upper nibble 0x2 issues nothing (out_valid is 0 in the next cycle) and sets the operand register to (register OR nibble) shifted left by 4, modulo 2^32.
- R4: An accepted byte with upper nibble 0x6 issues nothing and sets the operand register to the bitwise complement of (register OR nibble), shifted left by 4, modulo 2^32.
- R5: An accepted byte with upper nibble 0xF is issued with func 0xF, is_secondary 1, and operand equal to the combined operand, which is the secondary operation code (for example 0x05 or 0x10).
- R6: After any issued byte the operand register is zero, so the next instruction starts from an empty operand.
- R7: in_ready equals (not out_valid) or out_ready, and while out_valid is 1 and out_ready is 0, out_valid, func, operand and is_secondary hold steady.
- R8: When the output is drained and a new byte is accepted in the same cycle, no decoded instruction is lost or repeated, and they leave in byte order.
- R9: Runs of up to eight consecutive prefix bytes of either kind, mixed freely, give the operand defined by applying R3 and R4 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte: function nibble [7:4], data nibble [3:0] |
| in_ready | output | 1 | Decoder takes the byte at this edge |
| out_valid | output | 1 | Decoded instruction present |
| out_ready | input | 1 | Consumer takes the decoded instruction |
| func | output | 4 | Function code of the issued byte |
| operand | output | 32 | Immediate operand, or secondary operation code |
| is_secondary | output | 1 | Operand is a secondary operation code |

## Verification
Two events can meet in one cycle: the consumer drains the output register while a new byte is taken. The new byte is either a prefix, which must leave the output empty, or a completing byte, which must refill it at once. The bench provokes this by feeding bytes back to back while out_ready follows a pseudo-random pattern, so stalls, drains and refills fall against each other in all combinations. A scoreboard of instructions predicted from the byte stream is compared with each handshake at the output. A loss, a duplicate, a reordering or a wrong operand then shows up as a mismatch or as leftover entries.

// File: rtl/nd_pkg.sv
package nd_pkg;

  localparam int ND_NIB_W = 4;

  localparam logic [ND_NIB_W-1:0] FN_WIDEN  = 4'h2;
  localparam logic [ND_NIB_W-1:0] FN_INVERT = 4'h6;
  localparam logic [ND_NIB_W-1:0] FN_OPERATE = 4'hF;

  typedef enum logic [1:0] {
    K_PRIMARY = 2'd0,
    K_WIDEN   = 2'd1,
    K_INVERT  = 2'd2,
    K_OPERATE = 2'd3
  } byte_kind_t;

  function automatic logic kind_is_prefix(input byte_kind_t k);
    return (k == K_WIDEN) || (k == K_INVERT);
  endfunction

endpackage

// File: rtl/nd_func_class.sv
module nd_func_class
  import nd_pkg::*;
#(
  parameter int NIB_W  = ND_NIB_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [NIB_W-1:0]  fn,
  output logic [NIB_W-1:0]  nib,
  output byte_kind_t        kind
);

  assign fn  = byte_in[BYTE_W-1:NIB_W];
  assign nib = byte_in[NIB_W-1:0];

  always_comb begin
    if (fn == NIB_W'(FN_WIDEN))        kind = K_WIDEN;
    else if (fn == NIB_W'(FN_INVERT))  kind = K_INVERT;
    else if (fn == NIB_W'(FN_OPERATE)) kind = K_OPERATE;
    else                               kind = K_PRIMARY;
  end

endmodule

// File: rtl/nd_operand_acc.sv
module nd_operand_acc
  import nd_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int NIB_W  = ND_NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  byte_kind_t        kind,
  input  logic [NIB_W-1:0]  nib,
  output logic [OPND_W-1:0] merged,
  output logic [OPND_W-1:0] acc_q
);

  function automatic logic [OPND_W-1:0] f_merge(input logic [OPND_W-1:0] r,
                                                input logic [NIB_W-1:0] n);
    return r | OPND_W'(n);
  endfunction

  function automatic logic [OPND_W-1:0] f_widen(input logic [OPND_W-1:0] v);
    return v << NIB_W;
  endfunction

  assign merged = f_merge(acc_q, nib);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step) begin
      case (kind)
        K_WIDEN:  acc_q <= f_widen(merged);
        K_INVERT: acc_q <= f_widen(~merged);
        default:  acc_q <= '0;
      endcase
    end
  end

  // R6: a completing byte leaves an empty operand
  a_r6_clear_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !kind_is_prefix(kind)) |=> (acc_q == '0));

  // R3: widen prefix shifts the combined value up by one nibble
  a_r3_widen_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == K_WIDEN) |=> (acc_q == ($past(merged) << NIB_W)));

  // R4: invert prefix complements then shifts
  a_r4_invert_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == K_INVERT) |=> (acc_q == ((~$past(merged)) << NIB_W)));

  // R1: low nibble of the register is always empty between bytes
  a_r1_low_nibble_empty: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q[NIB_W-1:0] == '0);

endmodule

// File: rtl/nd_issue_stage.sv
module nd_issue_stage #(
  parameter int OPND_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NIB_W-1:0]  fn_in,
  input  logic [OPND_W-1:0] opnd_in,
  input  logic              sec_in,
  input  logic              take,
  output logic              valid_q,
  output logic [NIB_W-1:0]  fn_q,
  output logic [OPND_W-1:0] opnd_q,
  output logic              sec_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fn_q    <= '0;
      opnd_q  <= '0;
      sec_q   <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      fn_q    <= fn_in;
      opnd_q  <= opnd_in;
      sec_q   <= sec_in;
    end else if (take) begin
      valid_q <= 1'b0;
    end
  end

  // R7: a stalled result must not move
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !take) |=> (valid_q && $stable(fn_q) && $stable(opnd_q) && $stable(sec_q)));

endmodule

// File: rtl/nib_prefix_decoder.sv
module nib_prefix_decoder
  import nd_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int NIB_W  = ND_NIB_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NIB_W-1:0]  func,
  output logic [OPND_W-1:0] operand,
  output logic              is_secondary
);

  logic [NIB_W-1:0]  cur_fn;
  logic [NIB_W-1:0]  cur_nib;
  byte_kind_t        cur_kind;
  logic [OPND_W-1:0] cur_merged;
  logic [OPND_W-1:0] acc_q;

  // named events for the checks below
  logic ev_accept;
  logic ev_prefix;
  logic ev_issue;
  logic ev_drain;

  assign in_ready  = !out_valid || out_ready;
  assign ev_accept = in_valid && in_ready;
  assign ev_prefix = ev_accept && kind_is_prefix(cur_kind);
  assign ev_issue  = ev_accept && !kind_is_prefix(cur_kind);
  assign ev_drain  = out_valid && out_ready;

  nd_func_class #(.NIB_W(NIB_W)) u_class (
    .byte_in (in_byte),
    .fn      (cur_fn),
    .nib     (cur_nib),
    .kind    (cur_kind)
  );

  nd_operand_acc #(.OPND_W(OPND_W), .NIB_W(NIB_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (ev_accept),
    .kind   (cur_kind),
    .nib    (cur_nib),
    .merged (cur_merged),
    .acc_q  (acc_q)
  );

  nd_issue_stage #(.OPND_W(OPND_W), .NIB_W(NIB_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_issue),
    .fn_in   (cur_fn),
    .opnd_in (cur_merged),
    .sec_in  (cur_kind == K_OPERATE),
    .take    (ev_drain),
    .valid_q (out_valid),
    .fn_q    (func),
    .opnd_q  (operand),
    .sec_q   (is_secondary)
  );

  // R3 / R4: a prefix byte never produces output
  a_r3_prefix_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prefix |=> !out_valid);

  // R2 / R8: a completing byte is visible next cycle, even if a drain coincided
  a_r8_issue_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> (out_valid && func == $past(cur_fn) && operand == $past(cur_merged)));

  // R5: the secondary flag matches the operate code
  a_r5_secondary_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (is_secondary == (func == NIB_W'(FN_OPERATE))));

  // R7: no byte is taken while a result is stuck
  a_r7_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !ev_accept);

endmodule

// File: tb/test_nib_prefix_decoder.sv
`timescale 1ns/1ps
module test_nib_prefix_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  func;
  logic [31:0] operand;
  logic        is_secondary;

  always #2.5 clk = ~clk;

  nib_prefix_decoder i_nib_prefix_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .func(func), .operand(operand), .is_secondary(is_secondary)
  );

  int checks = 0;
  int errors = 0;
  logic [36:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model_reg = 32'h0;
  int          ready_mode = 0;
  logic [7:0]  lfsr = 8'h5A;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent reference: value after the byte, and what it issues
  task automatic send(input logic [7:0] b, input string tag);
    logic [31:0] comb;
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    comb = model_reg | {28'h0, b[3:0]};
    if (b[7:4] == 4'h2)      model_reg = comb * 32'd16;
    else if (b[7:4] == 4'h6) model_reg = (32'hFFFF_FFFF ^ comb) * 32'd16;
    else begin
      exp_q.push_back({b[7:4] == 4'hF, b[7:4], comb});
      tag_q.push_back(tag);
      model_reg = 32'h0;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // monitor: drives out_ready, compares handshakes with the scoreboard
  logic        was_stalled = 1'b0;
  logic [36:0] stall_snap;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
      if (was_stalled)
        chk(out_valid && {is_secondary, func, operand} == stall_snap, "R7",
            "stalled output moved", {27'h0, out_valid, is_secondary, func, operand},
            {27'h0, 1'b1, stall_snap});
      #1;
      chk(in_ready == (!out_valid || out_ready), "R7", "in_ready rule",
          {63'h0, in_ready}, {63'h0, !out_valid || out_ready});
      was_stalled = out_valid && !out_ready;
      stall_snap  = {is_secondary, func, operand};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected output (prefix issued or duplicate, R8)",
              {27'h0, is_secondary, func, operand}, 64'h0);
        end else begin
          logic [36:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({is_secondary, func, operand} == e, t, "decoded instruction",
              {27'h0, is_secondary, func, operand}, {27'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", {63'h0, out_valid}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {63'h0, in_ready}, 64'h1);

    send(8'h47, "R1");                       // first operand equals own nibble
    send(8'h0A, "R2");                       // plain primary
    send(8'h21, "R3"); send(8'h22, "R3"); send(8'h43, "R3");   // 0x123
    @(negedge clk); #1;
    send(8'h2A, "R3");
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R3", "prefix issues nothing", {63'h0, out_valid}, 64'h0);
    send(8'hD5, "R3");                       // 0xA5
    send(8'h60, "R4"); send(8'h4F, "R4");    // all ones
    send(8'h61, "R4"); send(8'h83, "R4");    // ~1<<4 | 3
    send(8'hF5, "R5");                       // secondary 0x05
    send(8'h21, "R5"); send(8'hF0, "R5");    // secondary 0x10
    send(8'h2F, "R6"); send(8'h9C, "R6");
    send(8'h03, "R6");                       // register cleared
    for (int i = 1; i <= 8; i++) send({4'h2, 4'(i)}, "R9");
    send(8'h49, "R9");
    send(8'h27, "R9"); send(8'h6E, "R9"); send(8'h23, "R9"); send(8'h61, "R9");
    send(8'h2B, "R9"); send(8'h6C, "R9"); send(8'h24, "R9"); send(8'h65, "R9");
    send(8'hE1, "R9");

    ready_mode = 1;                          // drains and accepts collide
    for (int k = 0; k < 120; k++) begin
      logic [7:0] b;
      b = 8'((k * 37 + 11) ^ (k >> 2));
      send(b, "R8");
    end
    ready_mode = 0;
    repeat (6) @(negedge clk);
    #2;
    chk(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 64'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule